// File: doc/BRIEF.md
# Directed-Mode Mantissa Rounding Stage

This block takes a mantissa that still carries two extra low-order bits, plus a separate sticky bit, a sign and a two-bit mode. It removes the two extra bits and, depending on the mode, adds one to what is left. The carry runs through the full width. The result is held in one register stage. Along with the rounded mantissa it reports three things: whether the increment was applied, whether the value was inexact, and whether an overflowing result of this sign and mode would saturate to infinity or to the largest finite value. When the carry reaches the next power of two, the result is presented as-is in a spare top bit, and renormalising it is the downstream packer's job. Exponents are not handled here.

Data enters and leaves through valid/ready handshakes. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. An offered output stays unchanged until `out_ready` takes it, so back-pressure costs no data. The latency is one cycle.

Top module: `dir_round_unit`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: When guard (input bit 1), round (input bit 0) and sticky are all zero, `out_mant` equals the input shifted right by two, and `out_rounded_up` and `out_inexact` are both low.
- R3: Mode 00 (nearest) increments only when guard is set and at least one of round, sticky or the shifted LSB is set. A tie therefore rounds to even.
- R4: Mode 01 (toward zero) never increments.
- R5: Mode 10 (toward plus infinity) increments a non-exact value only when the sign is 0. Mode 11 (toward minus infinity) increments a non-exact value only when the sign is 1.
- R6: `out_inexact` is high for every non-exact input, whatever the mode.
- R7: `out_to_inf` is 1 in mode 00, 0 in mode 01, equal to the inverted sign in mode 10, and equal to the sign in mode 11. This holds for every input.
- R8: `out_rounded_up` is high exactly when the increment was applied, and then `out_mant` equals the shifted input plus one.
- R9: When the shifted input is all ones and is incremented, `out_mant` has only its top bit (bit MANT_W) set. No renormalisation is done.
- R10: An accepted word appears at the output on the next edge. While `out_valid` is high and `out_ready` is low, `in_ready` is low and every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Stage can take a word |
| in_mant | input | MANT_W+2 | Mantissa with guard (bit 1) and round (bit 0) |
| in_sticky | input | 1 | OR of all bits below round |
| in_sign | input | 1 | Sign, 1 = negative |
| in_mode | input | 2 | 00 nearest, 01 zero, 10 plus inf, 11 minus inf |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_mant | output | MANT_W+1 | Rounded mantissa, top bit is carry-out |
| out_rounded_up | output | 1 | Increment was applied |
| out_inexact | output | 1 | Dropped bits were non-zero |
| out_to_inf | output | 1 | Overflow goes to infinity (else to max finite) |

## Verification
With a four-bit mantissa the bench sweeps every combination of input mantissa, sticky, sign and mode, and computes the expected result arithmetically. The sweep contains several kinds of input, and each tells a different fault apart. Exact inputs separate the no-change path from a spurious increment. Guard-only inputs with even and odd LSBs expose a broken tie-to-even rule. Inputs with only round or only sticky set show whether the directed modes look at sign rather than at guard. The all-ones mantissas check that the carry runs the full width. A stalled-output sequence confirms that a held result is not overwritten and that the queued word follows it once the consumer drains the output.

// File: rtl/dir_round_pkg.sv
package dir_round_pkg;
  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_PLUS    = 2'b10,
    RM_MINUS   = 2'b11
  } rmode_e;
endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
  import dir_round_pkg::*;
(
  input  logic       lsb,
  input  logic       guard_b,
  input  logic       round_b,
  input  logic       sticky,
  input  logic       sign,
  input  logic [1:0] mode,
  output logic       incr,
  output logic       inexact,
  output logic       to_inf
);
  logic lost;
  assign lost = guard_b | round_b | sticky;

  always_comb begin
    incr = 1'b0;
    if (lost) begin
      unique case (mode)
        RM_NEAREST: incr = guard_b & (round_b | sticky | lsb);
        RM_ZERO:    incr = 1'b0;
        RM_PLUS:    incr = ~sign;
        RM_MINUS:   incr = sign;
        default:    incr = 1'b0;
      endcase
    end
  end

  always_comb begin
    unique case (mode)
      RM_NEAREST: to_inf = 1'b1;
      RM_ZERO:    to_inf = 1'b0;
      RM_PLUS:    to_inf = ~sign;
      RM_MINUS:   to_inf = sign;
      default:    to_inf = 1'b1;
    endcase
  end

  assign inexact = lost;

  // R4: toward-zero mode must never request an increment
  always_comb begin
    a_r4_zero_no_incr: assert (!(mode == RM_ZERO && incr));
  end
endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
  parameter int W = 24
) (
  input  logic [W-1:0] a,
  input  logic         inc,
  output logic [W:0]   sum
);
  logic [W:0] carry;
  assign carry[0] = inc;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = a[i] ^ carry[i];
    assign carry[i+1] = a[i] & carry[i];
  end
  assign sum[W] = carry[W];
endmodule

// File: rtl/dir_round_unit.sv
module dir_round_unit
  import dir_round_pkg::*;
#(
  parameter int MANT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [MANT_W+1:0] in_mant,
  input  logic              in_sticky,
  input  logic              in_sign,
  input  logic [1:0]        in_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [MANT_W:0]   out_mant,
  output logic              out_rounded_up,
  output logic              out_inexact,
  output logic              out_to_inf
);
  localparam int IN_W = MANT_W + 2;

  logic [MANT_W-1:0] shifted;
  logic              inc_c, inx_c, inf_c;
  logic [MANT_W:0]   sum_c;
  logic              in_fire;

  assign shifted = in_mant[IN_W-1:2];

  rnd_decide u_decide (
    .lsb     (in_mant[2]),
    .guard_b (in_mant[1]),
    .round_b (in_mant[0]),
    .sticky  (in_sticky),
    .sign    (in_sign),
    .mode    (in_mode),
    .incr    (inc_c),
    .inexact (inx_c),
    .to_inf  (inf_c)
  );

  rnd_incr #(.W(MANT_W)) u_incr (
    .a   (shifted),
    .inc (inc_c),
    .sum (sum_c)
  );

  assign in_ready = ~out_valid | out_ready;
  assign in_fire  = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_mant       <= '0;
      out_rounded_up <= 1'b0;
      out_inexact    <= 1'b0;
      out_to_inf     <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_mant       <= sum_c;
        out_rounded_up <= inc_c;
        out_inexact    <= inx_c;
        out_to_inf     <= inf_c;
      end
    end
  end

  // R2: exact input passes through unchanged
  a_r2_exact_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_mant[1:0] == 2'b00 && !in_sticky
    |=> out_mant == {1'b0, $past(shifted)} && !out_inexact && !out_rounded_up);

  // R6: any dropped bit raises inexact
  a_r6_inexact_set: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && (in_mant[1:0] != 2'b00 || in_sticky) |=> out_inexact);

  // R7: nearest mode always saturates to infinity
  a_r7_nearest_inf: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_mode == RM_NEAREST |=> out_to_inf);

  // R8: a round-up result is one above the shifted input
  a_r8_up_plus_one: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_mant == {1'b0, $past(shifted)} + (MANT_W+1)'(out_rounded_up));

  // R10: stalled output holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_mant)
      && $stable(out_rounded_up) && $stable(out_inexact) && $stable(out_to_inf));

  // R10: no acceptance while stalled
  a_r10_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/test_dir_round_unit.sv
module test_dir_round_unit;
  localparam int MW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [MW+1:0] in_mant = '0;
  logic in_sticky = 1'b0;
  logic in_sign = 1'b0;
  logic [1:0] in_mode = 2'b00;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [MW:0] out_mant;
  logic out_rounded_up, out_inexact, out_to_inf;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dir_round_unit #(.MANT_W(MW)) i_dir_round_unit (
    .clk, .rst_n, .in_valid, .in_ready, .in_mant, .in_sticky, .in_sign,
    .in_mode, .out_valid, .out_ready, .out_mant, .out_rounded_up,
    .out_inexact, .out_to_inf
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 64; m++) begin
      for (int st = 0; st < 2; st++) begin
        for (int sg = 0; sg < 2; sg++) begin
          for (int md = 0; md < 4; md++) begin
            int v, g, r, exact, inc, inf, em;
            string tag;
            v = m >> 2; g = (m >> 1) & 1; r = m & 1;
            exact = (g == 0 && r == 0 && st == 0);
            inc = 0;
            if (!exact) begin
              case (md)
                0: inc = (g == 1 && (r == 1 || st == 1 || (v & 1) == 1)) ? 1 : 0;
                1: inc = 0;
                2: inc = (sg == 0) ? 1 : 0;
                default: inc = sg;
              endcase
            end
            inf = (md == 0) ? 1 : (md == 1) ? 0 : (md == 2) ? 1 - sg : sg;
            em = v + inc;
            if (exact) tag = "R2 mant";
            else if (v == 15 && inc == 1) tag = "R9 mant";
            else if (md == 0) tag = "R3 mant";
            else if (md == 1) tag = "R4 mant";
            else tag = "R5 mant";

            in_mant = m[MW+1:0]; in_sticky = st[0]; in_sign = sg[0];
            in_mode = md[1:0]; in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            chk("R10 out_valid", int'(out_valid), 1);
            chk(tag, int'(out_mant), em);
            chk("R8 rounded_up", int'(out_rounded_up), inc);
            chk("R6 inexact", int'(out_inexact), 1 - exact);
            chk("R7 to_inf", int'(out_to_inf), inf);
          end
        end
      end
    end

    // R10: back-pressure sequence
    @(negedge clk);
    out_ready = 1'b0;
    in_mant = 6'b000110; in_sticky = 0; in_sign = 0; in_mode = 2'b00; in_valid = 1;
    @(negedge clk);  // A=1 g=1 r=0 odd -> 2
    chk("R10 in_ready stalled", int'(in_ready), 0);
    in_mant = 6'b001001; in_mode = 2'b01; // B: 2, no inc
    @(negedge clk);
    chk("R10 hold mant", int'(out_mant), 2);
    chk("R10 hold up", int'(out_rounded_up), 1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 next mant", int'(out_mant), 2);
    chk("R10 next up", int'(out_rounded_up), 0);
    chk("R10 next inexact", int'(out_inexact), 1);
    @(negedge clk);
    chk("R10 drained", int'(out_valid), 0);

    finished = 1'b1;
    summary();
  end
endmodule